// File: doc/BRIEF.md
# Superscalar Register Rename Unit

This block renames a group of up to four instructions in one cycle. Each lane carries two logical source registers and one logical destination register, all 5 bits wide. A map table with one entry per logical register holds the physical register (7 bits) currently standing for it. Each valid destination takes a fresh physical register from a free pool, and the map table is updated at the clock edge.

Sources that read a register written by an older lane of the same group cannot use the table, because the table still holds the pre-group mapping. A comparator network checks each source against the destinations of every older lane. On a match, a multiplexer forwards that lane's newly allocated register in place of the table value.

Up to four shadow copies of the map table are kept as a shift chain, and any one of them can be copied back into the active table in a single cycle. Registers freed at commit come back one per cycle through a return port. Rename results are combinational in the cycle the group is presented and are valid only while `renValid` is high.

Top module: `renameUnit`

## Requirements
- R1: After reset, logical register i maps to physical register i, every shadow copy holds that same mapping, and the free pool holds physical registers 32 to 127 in ascending order, with 32 at its head.
- R2: A valid source with no matching destination in an older valid lane of its group gets the map-table entry of its logical register.
- R3: A valid source whose logical register equals the destination of one or more older valid lanes gets the physical destination of the youngest such lane. The lane's own destination and younger lanes are never used.
- R4: In an accepted group, valid lanes take physical destinations from the head of the free pool in lane order, lane 0 first. Invalid lanes take none. The pool shrinks by the number of valid lanes.
- R5: On acceptance, every valid destination's mapping is written at the clock edge. When several lanes name the same destination, the youngest lane's register stays.
- R6: When the pool holds fewer registers than the group has valid lanes, the whole group is refused: `stall` is 1, `renValid` is 0, and neither the pool nor the map table changes.
- R7: A return strobe appends the returned register to the tail of the pool at the clock edge. A register returned in one cycle cannot be allocated in that same cycle.
- R8: A save request shifts shadow copy k into copy k+1, drops the oldest copy, and places in copy 0 the active table as it stood before that cycle's group writes.
- R9: A restore request copies the selected shadow copy into the active table in one cycle. In that cycle the group is refused (`stall` high when lanes are valid), a save request is ignored, and the shadow copies and free pool stay as they were apart from a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneValid | input | 4 | One bit per lane: lane holds an instruction |
| srcA | input | 4 x 5 | First logical source per lane |
| srcB | input | 4 x 5 | Second logical source per lane |
| dstLog | input | 4 x 5 | Logical destination per lane |
| saveReq | input | 1 | Push the active table into the shadow chain |
| restoreReq | input | 1 | Copy a shadow copy into the active table |
| restoreSel | input | 2 | Shadow copy to restore (0 is the newest) |
| relValid | input | 1 | Return one physical register to the pool |
| relReg | input | 7 | Physical register being returned |
| renValid | output | 1 | Group accepted this cycle |
| stall | output | 1 | Valid group refused this cycle |
| physA | output | 4 x 7 | Physical register for srcA per lane |
| physB | output | 4 x 7 | Physical register for srcB per lane |
| physDst | output | 4 x 7 | Newly allocated physical destination per lane |

## Verification
The bench drives a small set of directed groups before a long random run, and on every cycle compares the outputs with a behavioural model. The first directed group sets the reset mapping apart from any later state. A chain of lanes that write and read the same few registers shows whether forwarding picks the youngest older writer and ignores the lane's own write. A group with every destination equal tells a last-writer table update from a first-writer one. The save, write and restore sequences show whether the pre-group table is the one saved, and the draining phase with a return in the stalled cycle shows when a returned register becomes usable. The random run draws registers from a narrow range in some cycles and the full range in others, so it covers both dense and sparse dependences, and mixes saves, restores and returns.

// File: rtl/renamePkg.sv
package renamePkg;
  localparam int LOG_W  = 5;
  localparam int PHYS_W = 7;
  localparam int IW     = 4;
  localparam int CKPT_N = 4;
  localparam int NLOG   = 1 << LOG_W;
  localparam int NPHYS  = 1 << PHYS_W;
  localparam int CKPT_W = $clog2(CKPT_N);
  localparam int CNT_W  = PHYS_W + 1;
  localparam int LANE_W = $clog2(IW + 1);

  typedef struct packed {
    logic              accept;
    logic              doSave;
    logic              doRestore;
    logic [CKPT_W-1:0] restoreSel;
    logic [LANE_W-1:0] allocCount;
  } ctlStrobes_t;
endpackage

// File: rtl/renameCtl.sv
module renameCtl
  import renamePkg::*;
(
  input  logic [IW-1:0]     laneValid,
  input  logic              saveReq,
  input  logic              restoreReq,
  input  logic [CKPT_W-1:0] restoreSel,
  input  logic [CNT_W-1:0]  freeCount,
  output ctlStrobes_t       strobes,
  output logic              stall
);
  logic [LANE_W-1:0] needCount;
  logic              anyLane;

  always_comb begin
    needCount = '0;
    for (int k = 0; k < IW; k++)
      needCount = needCount + LANE_W'(laneValid[k]);
  end

  assign anyLane = |laneValid;

  always_comb begin
    strobes.accept     = anyLane && !restoreReq && (freeCount >= CNT_W'(needCount));
    strobes.doSave     = saveReq && !restoreReq;
    strobes.doRestore  = restoreReq;
    strobes.restoreSel = restoreSel;
    strobes.allocCount = needCount;
  end

  assign stall = anyLane && !strobes.accept;
endmodule

// File: rtl/renameData.sv
module renameData
  import renamePkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobes_t                   strobes,
  input  logic [IW-1:0]                 laneValid,
  input  logic [IW-1:0][LOG_W-1:0]      srcA,
  input  logic [IW-1:0][LOG_W-1:0]      srcB,
  input  logic [IW-1:0][LOG_W-1:0]      dstLog,
  input  logic                          relValid,
  input  logic [PHYS_W-1:0]             relReg,
  output logic [IW-1:0][PHYS_W-1:0]     physA,
  output logic [IW-1:0][PHYS_W-1:0]     physB,
  output logic [IW-1:0][PHYS_W-1:0]     physDst,
  output logic [CNT_W-1:0]              freeCount
);
  logic [PHYS_W-1:0] mapTbl  [NLOG];
  logic [PHYS_W-1:0] shadow  [CKPT_N][NLOG];
  logic [PHYS_W-1:0] freeMem [NPHYS];
  logic [PHYS_W-1:0] headPtr, tailPtr;

  // allocation: valid lanes consume consecutive pool entries
  always_comb begin
    logic [PHYS_W-1:0] offset;
    offset = '0;
    for (int k = 0; k < IW; k++) begin
      physDst[k] = freeMem[headPtr + offset];
      if (laneValid[k]) offset = offset + 1'b1;
    end
  end

  // intra-group dependence check; later older-lane matches override
  always_comb begin
    for (int k = 0; k < IW; k++) begin
      physA[k] = mapTbl[srcA[k]];
      physB[k] = mapTbl[srcB[k]];
      for (int j = 0; j < k; j++) begin
        if (laneValid[j] && dstLog[j] == srcA[k]) physA[k] = physDst[j];
        if (laneValid[j] && dstLog[j] == srcB[k]) physB[k] = physDst[j];
      end
    end
  end

  // map table and shadow chain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NLOG; i++) begin
        mapTbl[i] <= PHYS_W'(i);
        for (int c = 0; c < CKPT_N; c++) shadow[c][i] <= PHYS_W'(i);
      end
    end else if (strobes.doRestore) begin
      for (int i = 0; i < NLOG; i++) mapTbl[i] <= shadow[strobes.restoreSel][i];
    end else begin
      if (strobes.doSave) begin
        for (int c = CKPT_N - 1; c > 0; c--) shadow[c] <= shadow[c-1];
        shadow[0] <= mapTbl;
      end
      if (strobes.accept)
        for (int k = 0; k < IW; k++)
          if (laneValid[k]) mapTbl[dstLog[k]] <= physDst[k];
    end
  end

  // free pool as a circular queue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NPHYS; i++)
        freeMem[i] <= (i < NPHYS - NLOG) ? PHYS_W'(i + NLOG) : '0;
      headPtr   <= '0;
      tailPtr   <= PHYS_W'(NPHYS - NLOG);
      freeCount <= CNT_W'(NPHYS - NLOG);
    end else begin
      if (relValid) begin
        freeMem[tailPtr] <= relReg;
        tailPtr          <= tailPtr + 1'b1;
      end
      if (strobes.accept) headPtr <= headPtr + PHYS_W'(strobes.allocCount);
      freeCount <= freeCount
                 - (strobes.accept ? CNT_W'(strobes.allocCount) : '0)
                 + CNT_W'(relValid);
    end
  end
endmodule

// File: rtl/renameUnit.sv
module renameUnit
  import renamePkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [IW-1:0]                 laneValid,
  input  logic [IW-1:0][LOG_W-1:0]      srcA,
  input  logic [IW-1:0][LOG_W-1:0]      srcB,
  input  logic [IW-1:0][LOG_W-1:0]      dstLog,
  input  logic                          saveReq,
  input  logic                          restoreReq,
  input  logic [CKPT_W-1:0]             restoreSel,
  input  logic                          relValid,
  input  logic [PHYS_W-1:0]             relReg,
  output logic                          renValid,
  output logic                          stall,
  output logic [IW-1:0][PHYS_W-1:0]     physA,
  output logic [IW-1:0][PHYS_W-1:0]     physB,
  output logic [IW-1:0][PHYS_W-1:0]     physDst
);
  ctlStrobes_t      strobes;
  logic [CNT_W-1:0] freeCount;

  renameCtl u_ctl (
    .laneValid (laneValid),
    .saveReq   (saveReq),
    .restoreReq(restoreReq),
    .restoreSel(restoreSel),
    .freeCount (freeCount),
    .strobes   (strobes),
    .stall     (stall)
  );

  renameData u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .laneValid(laneValid),
    .srcA     (srcA),
    .srcB     (srcB),
    .dstLog   (dstLog),
    .relValid (relValid),
    .relReg   (relReg),
    .physA    (physA),
    .physB    (physB),
    .physDst  (physDst),
    .freeCount(freeCount)
  );

  assign renValid = strobes.accept;
endmodule

// File: rtl/renameCheck.sv
module renameCheck
  import renamePkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic [IW-1:0]             laneValid,
  input logic                      restoreReq,
  input logic                      relValid,
  input logic                      renValid,
  input logic                      stall,
  input logic [IW-1:0][PHYS_W-1:0] physDst,
  input logic [CNT_W-1:0]          freeCount
);
  logic [CNT_W-1:0] need;
  always_comb begin
    need = '0;
    for (int k = 0; k < IW; k++) need = need + CNT_W'(laneValid[k]);
  end

  p_reset_pool_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> freeCount == CNT_W'(NPHYS - NLOG));

  p_short_pool_stalls_r6: assert property (@(posedge clk) disable iff (!rstN)
    (laneValid != '0 && freeCount < need) |-> (stall && !renValid));

  p_idle_pool_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!renValid && !relValid) |=> $stable(freeCount));

  p_alloc_shrinks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && !relValid) |=> freeCount == $past(freeCount) - $past(need));

  p_return_grows_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!renValid && relValid) |=> freeCount == $past(freeCount) + 1'b1);

  p_restore_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    restoreReq |-> !renValid);

  // R4: lanes of one accepted group never share a new register
  always_comb begin
    if (rstN && renValid)
      for (int i = 0; i < IW; i++)
        for (int j = i + 1; j < IW; j++)
          if (laneValid[i] && laneValid[j])
            p_distinct_alloc_r4: assert (physDst[i] != physDst[j]);
  end
endmodule

bind renameUnit renameCheck u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .laneValid (laneValid),
  .restoreReq(restoreReq),
  .relValid  (relValid),
  .renValid  (renValid),
  .stall     (stall),
  .physDst   (physDst),
  .freeCount (freeCount)
);

// File: tb/sim_renameUnit.sv
module sim_renameUnit;
  import renamePkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [IW-1:0] lv = '0;
  logic [IW-1:0][LOG_W-1:0] sa = '0, sb = '0, sd = '0;
  logic sv = 1'b0, rs = 1'b0, rv = 1'b0;
  logic [CKPT_W-1:0] sel = '0;
  logic [PHYS_W-1:0] rr = '0;
  logic renValid, stall;
  logic [IW-1:0][PHYS_W-1:0] physA, physB, physDst;

  int errors = 0, checks = 0;
  int mapM [NLOG];
  int shadM [CKPT_N][NLOG];
  int freeQ [$];
  int relPool [$];
  string phaseTag = "R2";

  always #5 clk = ~clk;

  renameUnit u0 (
    .clk(clk), .rstN(rstN), .laneValid(lv), .srcA(sa), .srcB(sb), .dstLog(sd),
    .saveReq(sv), .restoreReq(rs), .restoreSel(sel), .relValid(rv), .relReg(rr),
    .renValid(renValid), .stall(stall), .physA(physA), .physB(physB), .physDst(physDst)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int fwd(input int k, input int lg, input int dsts[IW]);
    int r = -1;
    for (int j = 0; j < k; j++) if (lv[j] && int'(sd[j]) == lg) r = dsts[j];
    return r;
  endfunction

  // caller sets inputs just after a falling edge; one cycle is compared and modelled
  task automatic step();
    int need = 0;
    bit accE;
    int dsts[IW];
    int idx = 0;
    #1;
    for (int k = 0; k < IW; k++) need += int'(lv[k]);
    accE = need > 0 && !rs && freeQ.size() >= need;
    chk(renValid == accE, rs ? "R9" : "R6", "renValid", renValid, accE);
    chk(stall == (need > 0 && !accE), rs ? "R9" : "R6", "stall", stall, need > 0 && !accE);
    if (accE) begin
      for (int k = 0; k < IW; k++) begin
        if (!lv[k]) continue;
        dsts[k] = freeQ[idx++];
        chk(int'(physDst[k]) == dsts[k], phaseTag == "R7" ? "R7" : "R4", "physDst", physDst[k], dsts[k]);
      end
      for (int k = 0; k < IW; k++) begin
        int f, e;
        if (!lv[k]) continue;
        f = fwd(k, int'(sa[k]), dsts);
        e = (f >= 0) ? f : mapM[sa[k]];
        chk(int'(physA[k]) == e, (f >= 0) ? "R3" : phaseTag, "physA", physA[k], e);
        f = fwd(k, int'(sb[k]), dsts);
        e = (f >= 0) ? f : mapM[sb[k]];
        chk(int'(physB[k]) == e, (f >= 0) ? "R3" : phaseTag, "physB", physB[k], e);
      end
    end
    @(posedge clk);
    if (rs) begin
      for (int i = 0; i < NLOG; i++) mapM[i] = shadM[sel][i];
    end else begin
      if (sv) begin
        for (int c = CKPT_N - 1; c > 0; c--) shadM[c] = shadM[c-1];
        shadM[0] = mapM;
      end
      if (accE)
        for (int k = 0; k < IW; k++)
          if (lv[k]) begin
            int p = freeQ.pop_front();
            mapM[sd[k]] = p;
            relPool.push_back(p);
          end
    end
    if (rv) freeQ.push_back(int'(rr));
    @(negedge clk);
  endtask

  task automatic idle();
    lv = '0; sv = 0; rs = 0; rv = 0;
  endtask

  task automatic randGroup(input int narrow);
    for (int k = 0; k < IW; k++) begin
      lv[k] = ($urandom_range(0, 4) != 0);
      sa[k] = narrow ? LOG_W'($urandom_range(0, 3)) : LOG_W'($urandom_range(0, NLOG - 1));
      sb[k] = narrow ? LOG_W'($urandom_range(0, 3)) : LOG_W'($urandom_range(0, NLOG - 1));
      sd[k] = narrow ? LOG_W'($urandom_range(0, 3)) : LOG_W'($urandom_range(0, NLOG - 1));
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NLOG; i++) begin
      mapM[i] = i;
      for (int c = 0; c < CKPT_N; c++) shadM[c][i] = i;
    end
    for (int i = NLOG; i < NPHYS; i++) freeQ.push_back(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: idle state, then identity mapping and pool head
    phaseTag = "R1";
    idle(); step();
    for (int k = 0; k < IW; k++) begin
      lv[k] = 1; sa[k] = LOG_W'(k); sb[k] = LOG_W'(k + 8); sd[k] = LOG_W'(k + 16);
    end
    step();
    chk(freeQ[0] == NLOG + IW, "R1", "model pool head", freeQ[0], NLOG + IW);

    // R3: chained dependences inside one group
    phaseTag = "R2";
    lv = '1;
    sa[0] = 5; sb[0] = 6; sd[0] = 1;
    sa[1] = 1; sb[1] = 1; sd[1] = 1;
    sa[2] = 1; sb[2] = 2; sd[2] = 2;
    sa[3] = 2; sb[3] = 1; sd[3] = 2;
    step();

    // R5: every lane writes register 9, then read it
    phaseTag = "R5";
    for (int k = 0; k < IW; k++) begin sa[k] = 0; sb[k] = 0; sd[k] = 9; end
    step();
    for (int k = 0; k < IW; k++) begin sa[k] = 9; sb[k] = 1; sd[k] = LOG_W'(20 + k); end
    step();

    // R8 / R9: save with same-cycle writes, further writes, restore with a group present
    phaseTag = "R8";
    sv = 1;
    for (int k = 0; k < IW; k++) begin sa[k] = 20; sb[k] = 9; sd[k] = LOG_W'(k + 9); end
    step();
    sv = 0;
    for (int k = 0; k < IW; k++) sd[k] = LOG_W'(k + 20);
    step();
    sv = 1; rs = 1; sel = 0; step();
    phaseTag = "R9";
    sv = 0; rs = 0;
    for (int k = 0; k < IW; k++) begin sa[k] = LOG_W'(k + 9); sb[k] = LOG_W'(k + 20); sd[k] = 30; end
    step();
    rs = 1; sel = 3; lv = '0; step();
    rs = 0; lv = '1;
    for (int k = 0; k < IW; k++) begin sa[k] = LOG_W'(k + 9); sb[k] = 20; sd[k] = 31; end
    step();

    // R6: drain the pool with no returns
    phaseTag = "R6";
    for (int n = 0; n < 30; n++) begin
      lv = '1; randGroup(0); lv = '1;
      step();
    end
    lv = '0;
    for (int k = 0; k < freeQ.size() && k < IW; k++) lv[k] = 1;
    step();
    lv = '1; step();

    // R7: return arrives in the cycle the group is short, usable next cycle
    phaseTag = "R7";
    while (freeQ.size() >= IW) begin lv = 4'b0001; step(); end
    lv = '0;
    for (int k = 0; k <= freeQ.size() && k < IW; k++) lv[k] = 1;
    rv = 1; rr = PHYS_W'(relPool.pop_front());
    step();
    rv = 0; step();

    // random mix
    phaseTag = "R2";
    for (int n = 0; n < 3000; n++) begin
      int narrow = (n / 200) % 2;
      randGroup(narrow);
      sv = ($urandom_range(0, 9) == 0);
      rs = ($urandom_range(0, 19) == 0);
      sel = CKPT_W'($urandom_range(0, CKPT_N - 1));
      rv = 0;
      if (relPool.size() > 0 && $urandom_range(0, 3) != 0) begin
        rv = 1; rr = PHYS_W'(relPool.pop_front());
      end
      step();
    end
    idle(); step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule